// File: doc/BRIEF.md
# Clock Lock Supervisor with Automatic Recovery

This block supervises a clock synthesizer from a free-running supervisory clock. After reset it holds the synthesizer in reset for a set number of cycles, releases it, and waits until the synthesizer's lock indication has stayed high for long enough. Only then does it declare the generated clock valid to downstream logic. While the clock is not valid, a downstream reset is held asserted.

The lock indication arrives asynchronously, so it is synchronized before any decision uses it. If lock is not reached within a timeout, the block resets the synthesizer again and counts the retry. If lock drops while the clock is valid, validity is withdrawn at once and the loss is counted. When automatic recovery is enabled, a fresh synthesizer reset follows. When it is disabled, the block waits in the lost state until a reset request arrives.

The controller runs four states: a reset phase, a wait-for-lock phase, a locked phase and a lost phase. A datapath holds the synchronizer and the counters. A thin top module joins the two.

Top module: `clk_lock_supervisor`

## Requirements
- R1: While `rst_n` is low, `synthRst` is 1, `clkValid` is 0, `downRst` is 1 and both event counters read 0.
- R2: Each synthesizer reset phase drives `synthRst` high for exactly RST_CYCLES consecutive supervisory clock cycles. The phase then moves to waiting for lock.
- R3: `lockedIn` passes through a two-stage synchronizer. `clkValid` rises only after the synchronized lock has been high for STABLE_CYCLES consecutive cycles of the wait phase. A single low sample restarts that count from zero.
- R4: `clkValid` is 1 only in the locked state. `downRst` is always the inverse of `clkValid`.
- R5: If the synchronized lock is low while in the locked state, `clkValid` falls on the next cycle and `lostCount` increments. A drop on `lockedIn` therefore reaches `clkValid` three clock edges later.
- R6: With `autoRecover` at 1, the lost state moves to a new synthesizer reset on the next cycle.
- R7: `lostCount` saturates at its all-ones value and never wraps.
- R8: With `autoRecover` at 0, the lost state holds `synthRst` at 0 and `clkValid` at 0, whatever `lockedIn` does, until `rstReq` is asserted.
- R9: If the wait phase lasts LOCK_TIMEOUT cycles without reaching lock, a new synthesizer reset starts and `retryCount` increments. `retryCount` saturates at all ones.
- R10: `rstReq` high at a clock edge forces the reset phase from any state without changing `lostCount`. Counting of the reset phase starts on the first cycle after the request is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running supervisory clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| rstReq | input | 1 | Synchronous request to restart the synthesizer |
| lockedIn | input | 1 | Asynchronous lock indication from the synthesizer |
| autoRecover | input | 1 | 1 lets a lost lock trigger a new synthesizer reset |
| synthRst | output | 1 | Reset to the synthesizer, high active |
| clkValid | output | 1 | Generated clock may be used |
| downRst | output | 1 | Reset for downstream logic, high while the clock is not valid |
| lostCount | output | LOST_W | Saturating count of locked-to-lost transitions |
| retryCount | output | RETRY_W | Saturating count of lock-acquisition timeouts |

## Verification
The hardest situation to reach from the ports is a lock glitch during the wait phase. The glitch must land early enough that the stability count restarts, but the timeout must not expire. The stimulus times a one-cycle low on `lockedIn` against the known two-edge synchronizer delay, so that the synchronized low is sampled while the count is still small. It then shows `clkValid` staying low on the cycle where an unbroken run would already have locked, and rising one full run later. Counter saturation is reached by repeating loss and timeout sequences, with small parameter values, until each counter sits at its maximum.

// File: rtl/lock_sup_pkg.sv
package lock_sup_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_LOCKED = 2'd2,
    ST_LOST   = 2'd3
  } supState_e;

  // control -> datapath
  typedef struct packed {
    logic countRst;
    logic countWait;
    logic bumpLost;
    logic bumpRetry;
  } supStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic rstDone;
    logic stableDone;
    logic timedOut;
    logic lockedSync;
  } supStatus_t;

endpackage

// File: rtl/lock_sup_dp.sv
module lock_sup_dp
  import lock_sup_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RST_CYCLES    = 16,
  parameter int STABLE_CYCLES = 64,
  parameter int LOCK_TIMEOUT  = 4096,
  parameter int LOST_W        = 8,
  parameter int RETRY_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lockedIn,
  input  supStrobe_t         strobe,
  output supStatus_t         status,
  output logic [LOST_W-1:0]  lostCount,
  output logic [RETRY_W-1:0] retryCount
);

  localparam int RstW   = $clog2(RST_CYCLES + 1);
  localparam int StabW  = $clog2(STABLE_CYCLES + 1);
  localparam int ToW    = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [LOST_W-1:0]  LostMax  = '1;
  localparam logic [RETRY_W-1:0] RetryMax = '1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [RstW-1:0]        rstCnt;
  logic [StabW-1:0]       stableCnt;
  logic [ToW-1:0]         toCnt;
  logic                   lockedSync;

  // synchronizer chain for the asynchronous lock indication
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], lockedIn};
  end
  assign lockedSync = syncQ[SYNC_STAGES-1];

  // length of the synthesizer reset phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rstCnt <= '0;
    else if (strobe.countRst) rstCnt <= rstCnt + 1'b1;
    else                     rstCnt <= '0;
  end

  // consecutive-lock run, cleared by any low sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             stableCnt <= '0;
    else if (strobe.countWait && lockedSync) stableCnt <= stableCnt + 1'b1;
    else                                    stableCnt <= '0;
  end

  // acquisition timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               toCnt <= '0;
    else if (strobe.countWait) toCnt <= toCnt + 1'b1;
    else                      toCnt <= '0;
  end

  // saturating event counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lostCount  <= '0;
      retryCount <= '0;
    end else begin
      if (strobe.bumpLost && lostCount != LostMax)    lostCount  <= lostCount + 1'b1;
      if (strobe.bumpRetry && retryCount != RetryMax) retryCount <= retryCount + 1'b1;
    end
  end

  assign status.lockedSync = lockedSync;
  assign status.rstDone    = strobe.countRst && (rstCnt == RstW'(RST_CYCLES - 1));
  assign status.stableDone = strobe.countWait && lockedSync &&
                             (stableCnt == StabW'(STABLE_CYCLES - 1));
  assign status.timedOut   = strobe.countWait && (toCnt == ToW'(LOCK_TIMEOUT - 1));

  // R3: a low synchronized sample restarts the run
  a_r3_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.countWait && !lockedSync) |=> (stableCnt == '0));

  // R7: loss counter steps by one below the top
  a_r7_lost_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.bumpLost && lostCount != LostMax) |=> (lostCount == $past(lostCount) + 1'b1));

  // R7: loss counter never wraps
  a_r7_lost_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (lostCount == LostMax) |=> (lostCount == LostMax));

  // R9: retry counter never wraps
  a_r9_retry_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (retryCount == RetryMax) |=> (retryCount == RetryMax));

endmodule

// File: rtl/lock_sup_ctrl.sv
module lock_sup_ctrl
  import lock_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rstReq,
  input  logic       autoRecover,
  input  supStatus_t status,
  output supStrobe_t strobe,
  output logic       synthRst,
  output logic       clkValid
);

  supState_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    nextState        = state;
    strobe.countRst  = (state == ST_RESET) && !rstReq;
    strobe.countWait = (state == ST_WAIT) && !rstReq;
    strobe.bumpLost  = 1'b0;
    strobe.bumpRetry = 1'b0;
    if (rstReq) begin
      nextState = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET: if (status.rstDone) nextState = ST_WAIT;
        ST_WAIT: begin
          if (status.stableDone) begin
            nextState = ST_LOCKED;
          end else if (status.timedOut) begin
            nextState        = ST_RESET;
            strobe.bumpRetry = 1'b1;
          end
        end
        ST_LOCKED: begin
          if (!status.lockedSync) begin
            nextState       = ST_LOST;
            strobe.bumpLost = 1'b1;
          end
        end
        ST_LOST: if (autoRecover) nextState = ST_RESET;
        default: nextState = ST_RESET;
      endcase
    end
  end

  assign synthRst = (state == ST_RESET);
  assign clkValid = (state == ST_LOCKED);

  // R2: leaving the reset phase only once its length is reached
  a_r2_reset_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && $past(state) == ST_RESET) |-> $past(status.rstDone));

  // R3: validity only after a complete stable run
  a_r3_valid_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkValid) |-> $past(status.stableDone));

  // R5: synchronized drop ends validity next cycle
  a_r5_drop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED && !status.lockedSync && !rstReq) |=> (!clkValid && state == ST_LOST));

  // R6: auto recovery restarts the synthesizer
  a_r6_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOST && autoRecover && !rstReq) |=> synthRst);

  // R8: without auto recovery the lost state holds
  a_r8_lost_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOST && !autoRecover && !rstReq) |=> (state == ST_LOST));

  // R10: a request always lands in the reset phase
  a_r10_request: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> synthRst);

endmodule

// File: rtl/clk_lock_supervisor.sv
module clk_lock_supervisor
  import lock_sup_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RST_CYCLES    = 16,
  parameter int STABLE_CYCLES = 64,
  parameter int LOCK_TIMEOUT  = 4096,
  parameter int LOST_W        = 8,
  parameter int RETRY_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rstReq,
  input  logic               lockedIn,
  input  logic               autoRecover,
  output logic               synthRst,
  output logic               clkValid,
  output logic               downRst,
  output logic [LOST_W-1:0]  lostCount,
  output logic [RETRY_W-1:0] retryCount
);

  supStrobe_t strobe;
  supStatus_t status;

  lock_sup_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rstReq      (rstReq),
    .autoRecover (autoRecover),
    .status      (status),
    .strobe      (strobe),
    .synthRst    (synthRst),
    .clkValid    (clkValid)
  );

  lock_sup_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .RST_CYCLES    (RST_CYCLES),
    .STABLE_CYCLES (STABLE_CYCLES),
    .LOCK_TIMEOUT  (LOCK_TIMEOUT),
    .LOST_W        (LOST_W),
    .RETRY_W       (RETRY_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lockedIn   (lockedIn),
    .strobe     (strobe),
    .status     (status),
    .lostCount  (lostCount),
    .retryCount (retryCount)
  );

  assign downRst = !clkValid;

  // R4: downstream reset mirrors validity
  a_r4_down_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    downRst != clkValid);

endmodule

// File: tb/sim_clk_lock_supervisor.sv
module sim_clk_lock_supervisor;

  localparam int RST_C = 4;
  localparam int STB_C = 5;
  localparam int TO_C  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rstReq = 1'b0;
  logic lockedIn = 1'b1;
  logic autoRecover = 1'b1;
  logic synthRst, clkValid, downRst;
  logic [1:0] lostCount, retryCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_lock_supervisor #(
    .SYNC_STAGES(2), .RST_CYCLES(RST_C), .STABLE_CYCLES(STB_C),
    .LOCK_TIMEOUT(TO_C), .LOST_W(2), .RETRY_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rstReq(rstReq), .lockedIn(lockedIn),
    .autoRecover(autoRecover), .synthRst(synthRst), .clkValid(clkValid),
    .downRst(downRst), .lostCount(lostCount), .retryCount(retryCount)
  );

  typedef struct packed {
    logic       lk;
    logic       ar;
    logic       rq;
    logic [7:0] n;
    logic       eSyn;
    logic       eVal;
    logic [1:0] eLost;
    logic [1:0] eRetry;
    logic [3:0] req;
  } vec_t;

  // lk ar rq  n  syn val lost retry req
  localparam vec_t TBL [28] = '{
    '{1'b1,1'b1,1'b0,8'd3, 1'b1,1'b0,2'd0,2'd0,4'd2},  // R2 still in reset
    '{1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,2'd0,2'd0,4'd2},  // R2 released
    '{1'b1,1'b1,1'b0,8'd4, 1'b0,1'b0,2'd0,2'd0,4'd3},  // R3 run incomplete
    '{1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,2'd0,2'd0,4'd3},  // R3 valid
    '{1'b0,1'b1,1'b0,8'd2, 1'b0,1'b1,2'd0,2'd0,4'd3},  // R3 synchronizer delay
    '{1'b0,1'b1,1'b0,8'd1, 1'b0,1'b0,2'd1,2'd0,4'd5},  // R5 lost
    '{1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,2'd1,2'd0,4'd6},  // R6 auto reset
    '{1'b1,1'b1,1'b0,8'd3, 1'b1,1'b0,2'd1,2'd0,4'd2},  // R2
    '{1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,2'd1,2'd0,4'd6},  // R6
    '{1'b1,1'b1,1'b0,8'd5, 1'b0,1'b1,2'd1,2'd0,4'd4},  // R4 relocked
    '{1'b0,1'b1,1'b0,8'd1, 1'b0,1'b1,2'd1,2'd0,4'd5},  // R5 glitch not yet seen
    '{1'b1,1'b1,1'b0,8'd2, 1'b0,1'b0,2'd2,2'd0,4'd5},  // R5 glitch loses lock
    '{1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,2'd2,2'd0,4'd6},  // R6
    '{1'b1,1'b1,1'b0,8'd9, 1'b0,1'b1,2'd2,2'd0,4'd4},  // R4
    '{1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,2'd3,2'd0,4'd7},  // R7 count 3
    '{1'b1,1'b0,1'b0,8'd10,1'b0,1'b0,2'd3,2'd0,4'd8},  // R8 held in lost
    '{1'b1,1'b0,1'b1,8'd1, 1'b1,1'b0,2'd3,2'd0,4'd10}, // R10 request
    '{1'b1,1'b0,1'b0,8'd3, 1'b1,1'b0,2'd3,2'd0,4'd2},  // R2
    '{1'b1,1'b0,1'b0,8'd1, 1'b0,1'b0,2'd3,2'd0,4'd10}, // R10
    '{1'b1,1'b0,1'b0,8'd5, 1'b0,1'b1,2'd3,2'd0,4'd4},  // R4
    '{1'b0,1'b1,1'b0,8'd3, 1'b0,1'b0,2'd3,2'd0,4'd7},  // R7 saturated
    '{1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,2'd3,2'd0,4'd6},  // R6
    '{1'b0,1'b1,1'b0,8'd4, 1'b0,1'b0,2'd3,2'd0,4'd9},  // R9 waiting
    '{1'b0,1'b1,1'b0,8'd19,1'b0,1'b0,2'd3,2'd0,4'd9},  // R9 before timeout
    '{1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,2'd3,2'd1,4'd9},  // R9 timeout
    '{1'b0,1'b1,1'b0,8'd24,1'b1,1'b0,2'd3,2'd2,4'd9},  // R9
    '{1'b0,1'b1,1'b0,8'd24,1'b1,1'b0,2'd3,2'd3,4'd9},  // R9
    '{1'b0,1'b1,1'b0,8'd24,1'b1,1'b0,2'd3,2'd3,4'd9}   // R9 saturated
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkAll(input int req, input logic eSyn, input logic eVal,
                        input int eLost, input int eRetry);
    chk(req, "synthRst", int'(synthRst), int'(eSyn));
    chk(req, "clkValid", int'(clkValid), int'(eVal));
    chk(req, "downRst", int'(downRst), int'(!eVal));  // R4
    chk(req, "lostCount", int'(lostCount), eLost);
    chk(req, "retryCount", int'(retryCount), eRetry);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chkAll(1, 1'b1, 1'b0, 0, 0);  // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < 28; i++) begin
      lockedIn    = TBL[i].lk;
      autoRecover = TBL[i].ar;
      rstReq      = TBL[i].rq;
      repeat (int'(TBL[i].n)) @(negedge clk);
      chkAll(int'(TBL[i].req), TBL[i].eSyn, TBL[i].eVal,
             int'(TBL[i].eLost), int'(TBL[i].eRetry));
    end
    // R3: a one-cycle glitch early in the wait phase restarts the run
    lockedIn = 1'b1;
    repeat (5) @(negedge clk);
    chkAll(3, 1'b0, 1'b0, 3, 3);
    lockedIn = 1'b0;
    @(negedge clk);
    lockedIn = 1'b1;
    repeat (6) @(negedge clk);
    chkAll(3, 1'b0, 1'b0, 3, 3);
    @(negedge clk);
    chkAll(3, 1'b0, 1'b1, 3, 3);
    // R10: request from the locked state leaves the loss count alone
    rstReq = 1'b1;
    @(negedge clk);
    rstReq = 1'b0;
    chkAll(10, 1'b1, 1'b0, 3, 3);
    // R1: asynchronous reset clears the counters
    rst_n = 1'b0;
    #1;
    chkAll(1, 1'b1, 1'b0, 0, 0);
    finishRun();
  end

endmodule